// File: doc/BRIEF.md
# Serial ADC Power-Mode Front End

This block is the digital side of an 8-bit serially read converter. A host drives an active-low chip select and a serial clock. The block counts the falling serial-clock edges in each frame. From the point in the frame where chip select returns high, it decides whether the converter stays in normal mode, drops into shutdown, or finishes waking up. The analog conversion is not modelled. The value to be sent is taken from a parallel input at the moment chip select falls. It is shifted out as a 16-position frame: three zeros, eight data bits MSB first, then zeros to the end of the frame.

Chip select and the serial clock are plain level inputs, sampled on the block's own clock `clk`. Their edges are found by comparing each input with its registered copy. No data stream with back-pressure crosses the block's edge. The sample input is a level that is read once per frame. The serial output is a data bit plus an output enable; the enable stands in for a high-impedance driver. Mode and frame results appear on plain status pins. `frame_done_o` is a one-cycle pulse, and `frame_valid_o` is meaningful only while that pulse is high.

Top module: `adcfe_top`

## Requirements
- R1: After reset, `mode_o` equals the start mode, with encoding 0 = normal, 1 = shutdown, 2 = powering up. The default start mode is normal. `sdata_oe` and `frame_done_o` are low.
- R2: After chip select falls, the output position starts at 0 and advances by one on each falling serial-clock edge. `sdata_o` is 0 at positions 0 to 2. Positions 3 to 10 carry the sample captured at the chip-select fall, MSB first. Positions 11 to 15 are 0.
- R3: The edge count restarts at every chip-select fall and saturates at 16. Extra edges keep `sdata_o` at 0, and the frame still counts as complete.
- R4: In normal mode, chip select rising after fewer than 2 falling edges leaves the mode normal and produces no done pulse.
- R5: In normal mode, chip select rising after 2 to 10 falling edges (inclusive) aborts the frame. The mode becomes shutdown and `sdata_oe` goes low, both one cycle after the rise is sampled.
- R6: In shutdown, `sdata_oe` stays low. A chip-select fall moves the mode to powering up one cycle later.
- R7: While powering up, chip select rising after 10 or fewer falling edges returns the mode to shutdown. Rising after 11 or more edges moves it to normal.
- R8: In normal mode, chip select rising after 11 to 15 edges ends the frame early. The mode stays normal and no done pulse is produced.
- R9: Chip select rising after 16 edges, in normal or powering-up mode, gives a one-cycle `frame_done_o` pulse one cycle after the rise is sampled.
- R10: The first conversion after reset, or after leaving shutdown, is a dummy and reports `frame_valid_o` = 0. A frame that passes 10 edges uses up the dummy. The next completed frame reports `frame_valid_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples all inputs |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host |
| sample_i | input | DATA_W | Value to send, captured at chip-select fall |
| sdata_o | output | 1 | Serial data bit |
| sdata_oe | output | 1 | Output enable; low means high impedance |
| mode_o | output | 2 | Current mode (0 normal, 1 shutdown, 2 powering up) |
| frame_done_o | output | 1 | One-cycle pulse at a completed frame |
| frame_valid_o | output | 1 | High with the done pulse when the frame is not a dummy |

## Verification
The hardest state to reach from the ports is the powering-up mode exactly at its threshold, with the dummy accounting carried across a wake. A wake frame ending at 10 edges must fall back to shutdown, while one ending at 11 edges must consume the dummy. The stimulus reaches this by aborting a normal frame to enter shutdown. It then issues wake frames with exact edge counts. Only the frame that follows a successful wake is checked for a valid result.

// File: rtl/adcfe_pkg.sv
package adcfe_pkg;
  typedef enum logic [1:0] {
    MD_NORMAL = 2'd0,
    MD_SHUT   = 2'd1,
    MD_WAKE   = 2'd2
  } mode_e;
endpackage

// File: rtl/adcfe_sync_edge.sv
// Registers each input level and flags any change against the stored copy.
module adcfe_sync_edge #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] q,
  output logic [W-1:0] chg
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) q[i] <= RST_VAL[i];
      else        q[i] <= lvl[i];
    end
    assign chg[i] = q[i] ^ lvl[i];
  end
endmodule

// File: rtl/adcfe_edge_count.sv
// Falling-edge counter: cleared at frame start, saturating at the frame length.
module adcfe_edge_count #(
  parameter int MAXV  = 16,
  parameter int CNT_W = $clog2(MAXV + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(MAXV);

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
  end

  // R3: the count never passes the frame length
  a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= TOP);
  // R3: once full, further edges hold it full
  a_r3_cnt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == TOP && inc && !clr) |=> cnt == TOP);
  // R3: frame start restarts the count
  a_r3_cnt_restart: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);
endmodule

// File: rtl/adcfe_mode_fsm.sv
// Mode tracking: shutdown entry, wake attempts, dummy-frame bookkeeping.
module adcfe_mode_fsm
  import adcfe_pkg::*;
#(
  parameter int FRAME_EDGES    = 16,
  parameter int SHUT_FIRST     = 2,
  parameter int SHUT_LAST      = 10,
  parameter bit START_SHUTDOWN = 1'b0,
  parameter int CNT_W          = $clog2(FRAME_EDGES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic [CNT_W-1:0] cnt,
  output mode_e            mode,
  output logic             done,
  output logic             valid
);
  localparam logic [CNT_W-1:0] LO   = CNT_W'(SHUT_FIRST);
  localparam logic [CNT_W-1:0] HI   = CNT_W'(SHUT_LAST);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_EDGES);
  localparam mode_e START = START_SHUTDOWN ? MD_SHUT : MD_NORMAL;

  logic dummy;
  logic in_abort;
  logic past_wake;

  assign in_abort  = (cnt >= LO) && (cnt <= HI);
  assign past_wake = cnt > HI;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode  <= START;
      dummy <= 1'b1;
      done  <= 1'b0;
      valid <= 1'b0;
    end else begin
      done  <= 1'b0;
      valid <= 1'b0;
      if (cs_fall && mode == MD_SHUT) begin
        mode <= MD_WAKE;
      end else if (cs_rise) begin
        unique case (mode)
          MD_NORMAL: begin
            if (in_abort) begin
              mode  <= MD_SHUT;
              dummy <= 1'b1;
            end else if (past_wake) begin
              dummy <= 1'b0;
              if (cnt == FULL) begin
                done  <= 1'b1;
                valid <= !dummy;
              end
            end
          end
          MD_WAKE: begin
            if (!past_wake) begin
              mode  <= MD_SHUT;
              dummy <= 1'b1;
            end else begin
              mode  <= MD_NORMAL;
              dummy <= 1'b0;
              if (cnt == FULL) done <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R4: early noise rise keeps normal mode, no result
  a_r4_short_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_NORMAL && cs_rise && cnt < LO) |=> (mode == MD_NORMAL && !done));
  // R5: rise inside the abort window enters shutdown
  a_r5_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_NORMAL && cs_rise && in_abort) |=> (mode == MD_SHUT && !done));
  // R6: select in shutdown starts waking
  a_r6_wake_start: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_SHUT && cs_fall) |=> mode == MD_WAKE);
  // R7: failed wake returns to shutdown
  a_r7_wake_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_WAKE && cs_rise && !past_wake) |=> mode == MD_SHUT);
  // R9: a valid flag only accompanies a done pulse
  a_r9_valid_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> done);
  // R10: a wake frame never reports valid data
  a_r10_wake_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_WAKE && cs_rise) |=> !valid);
endmodule

// File: rtl/adcfe_serout.sv
// Sample capture and frame-position to serial-bit mapping.
module adcfe_serout #(
  parameter int DATA_W     = 8,
  parameter int LEAD_ZEROS = 3,
  parameter int CNT_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] sample_i,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              drive,
  output logic              sdata
);
  localparam int LAST_POS = LEAD_ZEROS + DATA_W - 1;
  localparam int IDX_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [DATA_W-1:0] word;
  int pos;

  always_ff @(posedge clk) begin
    if (!rst_n)       word <= '0;
    else if (capture) word <= sample_i;
  end

  always_comb begin
    pos   = int'(cnt);
    sdata = 1'b0;
    if (drive && pos >= LEAD_ZEROS && pos <= LAST_POS)
      sdata = word[IDX_W'(LAST_POS - pos)];
  end

  // R2: leading positions always carry zero
  a_r2_lead_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cnt) < LEAD_ZEROS) |-> !sdata);
  // R2: a silent driver carries zero
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !drive |-> !sdata);
endmodule

// File: rtl/adcfe_top.sv
module adcfe_top
  import adcfe_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int LEAD_ZEROS     = 3,
  parameter int FRAME_EDGES    = 16,
  parameter int SHUT_FIRST     = 2,
  parameter int SHUT_LAST      = 10,
  parameter bit START_SHUTDOWN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic [DATA_W-1:0] sample_i,
  output logic              sdata_o,
  output logic              sdata_oe,
  output logic [1:0]        mode_o,
  output logic              frame_done_o,
  output logic              frame_valid_o
);
  localparam int CNT_W = $clog2(FRAME_EDGES + 1);

  logic [1:0] lvl_q, lvl_chg;
  logic cs_fall, cs_rise, sclk_fall;
  logic [CNT_W-1:0] cnt;
  mode_e mode;

  adcfe_sync_edge #(.W(2), .RST_VAL(2'b11)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl({sclk, cs_n}), .q(lvl_q), .chg(lvl_chg)
  );

  assign cs_fall   = lvl_chg[0] && !cs_n;
  assign cs_rise   = lvl_chg[0] &&  cs_n;
  assign sclk_fall = lvl_chg[1] && !sclk && !cs_n && !cs_fall;

  adcfe_edge_count #(.MAXV(FRAME_EDGES), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cs_fall), .inc(sclk_fall), .cnt(cnt)
  );

  adcfe_mode_fsm #(
    .FRAME_EDGES(FRAME_EDGES), .SHUT_FIRST(SHUT_FIRST), .SHUT_LAST(SHUT_LAST),
    .START_SHUTDOWN(START_SHUTDOWN), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise), .cnt(cnt),
    .mode(mode), .done(frame_done_o), .valid(frame_valid_o)
  );

  assign sdata_oe = !lvl_q[0] && (mode != MD_SHUT);
  assign mode_o   = mode;

  adcfe_serout #(.DATA_W(DATA_W), .LEAD_ZEROS(LEAD_ZEROS), .CNT_W(CNT_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .capture(cs_fall), .sample_i(sample_i),
    .cnt(cnt), .drive(sdata_oe), .sdata(sdata_o)
  );

  // R6: shutdown never drives the output
  a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd1) |-> (!sdata_oe && !sdata_o));
  // R9: done is a single-cycle pulse
  a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> !frame_done_o);
endmodule

// File: tb/sim_adcfe_top.sv
module sim_adcfe_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic [7:0] sample_i = 8'h00;
  logic sdata_o, sdata_oe, frame_done_o, frame_valid_o;
  logic [1:0] mode_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adcfe_top u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sample_i(sample_i),
    .sdata_o(sdata_o), .sdata_oe(sdata_oe), .mode_o(mode_o),
    .frame_done_o(frame_done_o), .frame_valid_o(frame_valid_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_bit(input logic [7:0] v, input int pos);
    if (pos >= 3 && pos <= 10) return int'(v[10 - pos]);
    return 0;
  endfunction

  task automatic set_cs(input logic val, input logic [7:0] v);
    @(negedge clk);
    cs_n = val;
    sample_i = v;
    @(posedge clk);
    #1;
  endtask

  task automatic one_edge();
    @(negedge clk); sclk = 1'b1;
    @(negedge clk); sclk = 1'b0;
    @(posedge clk);
    #1;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) one_edge();
  endtask

  // Full frame with bit checks; n >= 16 edges, expected mode after is normal.
  task automatic t_frame(input string req, input logic [7:0] v, input int n, input int exp_valid);
    set_cs(1'b0, v);
    chk("R2", "oe at frame start", int'(sdata_oe), 1);
    chk("R2", "bit pos 0", int'(sdata_o), 0);
    for (int i = 1; i <= n; i++) begin
      one_edge();
      if (exp_bit(v, i) != int'(sdata_o)) chk(req, "serial bit", int'(sdata_o), exp_bit(v, i));
      else checks++;
    end
    set_cs(1'b1, v);
    chk("R9", "done pulse", int'(frame_done_o), 1);
    chk(req, "valid flag", int'(frame_valid_o), exp_valid);
    chk(req, "mode after frame", int'(mode_o), 0);
    @(posedge clk); #1;
    chk("R9", "done drops", int'(frame_done_o), 0);
  endtask

  // Partial frame: raise select after n edges, check mode and no done.
  task automatic t_partial(input string req, input int n, input int exp_mode);
    set_cs(1'b0, 8'hFF);
    edges(n);
    set_cs(1'b1, 8'hFF);
    chk(req, "mode after partial", int'(mode_o), exp_mode);
    chk(req, "no done", int'(frame_done_o), 0);
    chk(req, "oe after rise", int'(sdata_oe), 0);
  endtask

  task automatic t_reset();
    chk("R1", "mode at reset", int'(mode_o), 0);
    chk("R1", "oe at reset", int'(sdata_oe), 0);
    chk("R1", "done at reset", int'(frame_done_o), 0);
  endtask

  task automatic t_shutdown_quiet();
    // R6: in shutdown, selecting moves to powering up
    chk("R6", "oe in shutdown", int'(sdata_oe), 0);
    set_cs(1'b0, 8'h00);
    chk("R6", "mode powering up", int'(mode_o), 2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_frame("R10", 8'hA5, 16, 0);        // dummy after reset
    t_frame("R2", 8'h3C, 16, 1);         // valid frame
    t_partial("R4", 0, 0);
    t_partial("R4", 1, 0);
    t_partial("R8", 11, 0);              // early end boundary
    t_partial("R8", 15, 0);
    t_frame("R8", 8'h81, 16, 1);         // still valid after early ends
    t_partial("R5", 10, 1);              // upper abort boundary
    chk("R5", "sdata quiet", int'(sdata_o), 0);
    t_shutdown_quiet();
    edges(10);
    set_cs(1'b1, 8'h00);
    chk("R7", "wake at 10 fails", int'(mode_o), 1);
    set_cs(1'b0, 8'h00);
    edges(11);
    set_cs(1'b1, 8'h00);
    chk("R7", "wake at 11 succeeds", int'(mode_o), 0);
    chk("R7", "no done on short wake", int'(frame_done_o), 0);
    t_frame("R10", 8'h5A, 16, 1);        // dummy consumed by wake
    t_partial("R5", 2, 1);               // lower abort boundary
    set_cs(1'b0, 8'h00);
    chk("R6", "powering up", int'(mode_o), 2);
    edges(16);
    set_cs(1'b1, 8'h00);
    chk("R9", "wake full frame done", int'(frame_done_o), 1);
    chk("R10", "wake frame invalid", int'(frame_valid_o), 0);
    chk("R7", "normal after wake", int'(mode_o), 0);
    t_frame("R10", 8'hC3, 16, 1);
    t_frame("R3", 8'hF0, 20, 1);         // overrun edges saturate
    t_frame("R3", 8'h0F, 16, 1);         // count restarted
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule